// File: doc/BRIEF.md
# Raster timing generator

This block produces the horizontal and vertical timing of a raster display from a set of programmable timing words. A pixel counter runs across each line and a line counter steps once per line. Both are compared against programmed positions to form the horizontal and vertical sync pulses, the horizontal and vertical blanking windows and a display-active strobe. The current line number and a field flag are also brought out, so software can follow the beam and tell the two fields of an interlaced frame apart.

Every timing field holds its position minus one. The pipe steps in this order along a line: active pixels, front porch, sync pulse, back porch. Sync and blanking are separate windows. The vertical blank can end a few lines before the frame does. Timing words are taken in only at a frame boundary, so a rewrite in the middle of a frame never produces a torn frame. Sync polarity and the power-state code act at once. Dropping the pipe enable freezes the counters, and the frozen line number tells software that the pipe has stopped. In interlaced mode each field is followed by one half line, and the field flag alternates from a chosen starting field.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel counter runs 0..T, where T is the upper half of `hTotalWord` ({total, active}), then wraps. The line counter, shown on `scanLine`, steps once per line wrap and returns to 0 after the line equal to the upper half of `vTotalWord` ({total, active}).
- R2: The raw horizontal sync is active for pixel counts c with S < c <= E, where `hSyncWord` = {E, S}. The raw vertical sync uses the same rule on the line count with `vSyncWord` = {E, S}.
- R3: `hBlank` is high for pixel counts c with B < c <= F, where `hBlankWord` = {F, B}. `vBlank` is high for line counts with the same rule on `vBlankWord`. A vertical blank end below the vertical total leaves the last lines of the frame unblanked.
- R4: `dispActive` is high only when neither blank is active and both counters are inside two bounds: the active fields (lower halves of the total words) and the source size. `srcSizeWord` = {width-1, height-1}.
- R5: Each sync output shows its raw active state when its polarity select is 1. It shows the inverted state when its polarity select is 0.
- R6: `pwrState` 0 drives both syncs normally. Code 1 holds hsync at its inactive level. Code 2 holds vsync at its inactive level. Code 3 holds both at their inactive levels. All codes act in the same cycle.
- R7: Timing words, source size and the interlace mode are captured only at a frame boundary, and on the first enabled cycle after reset. That first cycle loads the words and does not advance the counters.
- R8: While `pipeEn` is low, both counters hold, so `scanLine` and the blanking outputs stay constant. When `pipeEn` returns high, counting resumes from the held position.
- R9: In interlaced mode, every field ends with one half line of (T+1)/2 pixels. During the half line `scanLine` holds the vertical total, both blanks are high and both syncs are inactive.
- R10: In interlaced mode, `fieldOdd` takes the value of `oddFirst` on the first interlaced field and toggles at every later field boundary. It changes only when a field starts, and it is 0 in progressive mode.
- R11: During and right after reset, `scanLine` is 0, `fieldOdd` is 0 and both syncs sit at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pipeEn | input | 1 | Counters run while high |
| hTotalWord | input | 2*HW | {total, active}, each minus one |
| hSyncWord | input | 2*HW | {sync end, sync start}, minus one |
| hBlankWord | input | 2*HW | {blank end, blank start}, minus one |
| vTotalWord | input | 2*VW | {total, active} lines, minus one |
| vSyncWord | input | 2*VW | {sync end, sync start}, minus one |
| vBlankWord | input | 2*VW | {blank end, blank start}, minus one |
| srcSizeWord | input | HW+VW | {width-1, height-1} |
| hSyncPolHigh | input | 1 | 1 = hsync active high |
| vSyncPolHigh | input | 1 | 1 = vsync active high |
| pwrState | input | 2 | 0 on, 1 hsync off, 2 vsync off, 3 both off |
| interlaceEn | input | 1 | Interlaced mode request |
| oddFirst | input | 1 | First interlaced field is odd |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| hBlank | output | 1 | Horizontal blanking |
| vBlank | output | 1 | Vertical blanking |
| dispActive | output | 1 | Visible pixel |
| scanLine | output | VW | Current line count |
| fieldOdd | output | 1 | Odd-field indicator |

## Verification
The bench builds the block with its default 12-bit counters. It programs a small mode of 16 pixels by 9 lines, so that a whole frame lasts 144 clocks. This lets every porch edge, the vertical blank ending before the frame end, and a frame-boundary reload be checked within a few frames. A mid-frame rewrite that doubles the line length shows when new timing takes effect. A short interlaced run reaches the half line and two field toggles.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // strobes from the control to the counter datapath
  typedef struct packed {
    logic run;        // counters may step this cycle
    logic load;       // capture timing words into the shadow set
    logic lineWrap;   // pixel counter returns to zero
    logic nextLine;   // line counter increments
    logic frameWrap;  // line counter returns to zero, field ends
    logic halfLine;   // current line is the interlace half line
  } cntStrobe_t;
endpackage

// File: rtl/raster_win.sv
module raster_win #(
  parameter int W = 12
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  // window opens after lo and closes after hi (both stored minus one)
  assign hit = (cnt > lo) && (cnt <= hi);
endmodule

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pipeEn,
  input  logic       interlaceEn,
  input  logic       oddFirst,
  input  logic       lastPix,
  input  logic       lastLine,
  output cntStrobe_t stb,
  output logic       fieldOdd
);
  logic pending;     // no timing loaded since reset
  logic halfLine;
  logic ilSh;        // interlace mode of the running frame
  logic run, lineWrap, fieldEnd, enterHalf;

  always_comb begin
    run       = pipeEn & ~pending;
    lineWrap  = run & lastPix;
    fieldEnd  = lineWrap & (halfLine | (lastLine & ~ilSh));
    enterHalf = lineWrap & lastLine & ilSh & ~halfLine;
    stb.run       = run;
    stb.lineWrap  = lineWrap;
    stb.nextLine  = lineWrap & ~lastLine;
    stb.frameWrap = fieldEnd;
    stb.load      = (pipeEn & pending) | fieldEnd;
    stb.halfLine  = halfLine;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b1;
      halfLine <= 1'b0;
      ilSh     <= 1'b0;
      fieldOdd <= 1'b0;
    end else begin
      if (pipeEn) pending <= 1'b0;
      if (fieldEnd)       halfLine <= 1'b0;
      else if (enterHalf) halfLine <= 1'b1;
      if (stb.load) begin
        ilSh <= interlaceEn;
        if (!interlaceEn)              fieldOdd <= 1'b0;
        else if (ilSh && !pending)     fieldOdd <= ~fieldOdd;
        else                           fieldOdd <= oddFirst;
      end
    end
  end
endmodule

// File: rtl/raster_dp.sv
module raster_dp
  import raster_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        stb,
  input  logic [2*HW-1:0]   hTotalWord,
  input  logic [2*HW-1:0]   hSyncWord,
  input  logic [2*HW-1:0]   hBlankWord,
  input  logic [2*VW-1:0]   vTotalWord,
  input  logic [2*VW-1:0]   vSyncWord,
  input  logic [2*VW-1:0]   vBlankWord,
  input  logic [HW+VW-1:0]  srcSizeWord,
  input  logic              hSyncPolHigh,
  input  logic              vSyncPolHigh,
  input  logic [1:0]        pwrState,
  output logic              lastPix,
  output logic              lastLine,
  output logic              hSync,
  output logic              vSync,
  output logic              hBlank,
  output logic              vBlank,
  output logic              dispActive,
  output logic [VW-1:0]     scanLine
);
  logic [HW-1:0] hCnt, hTotR, hActR, hSsR, hSeR, hBsR, hBeR, srcWR;
  logic [VW-1:0] vCnt, vTotR, vActR, vSsR, vSeR, vBsR, vBeR, srcHR;
  logic [HW:0]   hLen;
  logic [HW-1:0] hHalfEnd;
  logic hSyncHit, vSyncHit, hBlankHit, vBlankHit, hSyncOn, vSyncOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0; vCnt <= '0;
      hTotR <= '0; hActR <= '0; hSsR <= '0; hSeR <= '0; hBsR <= '0; hBeR <= '0;
      vTotR <= '0; vActR <= '0; vSsR <= '0; vSeR <= '0; vBsR <= '0; vBeR <= '0;
      srcWR <= '0; srcHR <= '0;
    end else begin
      if (stb.load) begin
        {hTotR, hActR} <= hTotalWord;
        {hSeR, hSsR}   <= hSyncWord;
        {hBeR, hBsR}   <= hBlankWord;
        {vTotR, vActR} <= vTotalWord;
        {vSeR, vSsR}   <= vSyncWord;
        {vBeR, vBsR}   <= vBlankWord;
        {srcWR, srcHR} <= srcSizeWord;
      end
      if (stb.run) begin
        hCnt <= stb.lineWrap ? '0 : hCnt + 1'b1;
        if (stb.frameWrap)     vCnt <= '0;
        else if (stb.nextLine) vCnt <= vCnt + 1'b1;
      end
    end
  end

  // half line length is half the full line, rounded down
  assign hLen     = {1'b0, hTotR} + 1'b1;
  assign hHalfEnd = hLen[HW:1] - 1'b1;
  assign lastPix  = (hCnt == (stb.halfLine ? hHalfEnd : hTotR));
  assign lastLine = (vCnt == vTotR);

  raster_win #(.W(HW)) i_hSyncWin  (.cnt(hCnt), .lo(hSsR), .hi(hSeR), .hit(hSyncHit));
  raster_win #(.W(VW)) i_vSyncWin  (.cnt(vCnt), .lo(vSsR), .hi(vSeR), .hit(vSyncHit));
  raster_win #(.W(HW)) i_hBlankWin (.cnt(hCnt), .lo(hBsR), .hi(hBeR), .hit(hBlankHit));
  raster_win #(.W(VW)) i_vBlankWin (.cnt(vCnt), .lo(vBsR), .hi(vBeR), .hit(vBlankHit));

  always_comb begin
    hSyncOn    = hSyncHit & ~stb.halfLine & ~pwrState[0];
    vSyncOn    = vSyncHit & ~stb.halfLine & ~pwrState[1];
    hSync      = hSyncPolHigh ? hSyncOn : ~hSyncOn;
    vSync      = vSyncPolHigh ? vSyncOn : ~vSyncOn;
    hBlank     = hBlankHit | stb.halfLine;
    vBlank     = vBlankHit | stb.halfLine;
    dispActive = ~hBlank & ~vBlank & (hCnt <= hActR) & (vCnt <= vActR)
               & (hCnt <= srcWR) & (vCnt <= srcHR);
  end

  assign scanLine = vCnt;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pipeEn,
  input  logic [2*HW-1:0]  hTotalWord,
  input  logic [2*HW-1:0]  hSyncWord,
  input  logic [2*HW-1:0]  hBlankWord,
  input  logic [2*VW-1:0]  vTotalWord,
  input  logic [2*VW-1:0]  vSyncWord,
  input  logic [2*VW-1:0]  vBlankWord,
  input  logic [HW+VW-1:0] srcSizeWord,
  input  logic             hSyncPolHigh,
  input  logic             vSyncPolHigh,
  input  logic [1:0]       pwrState,
  input  logic             interlaceEn,
  input  logic             oddFirst,
  output logic             hSync,
  output logic             vSync,
  output logic             hBlank,
  output logic             vBlank,
  output logic             dispActive,
  output logic [VW-1:0]    scanLine,
  output logic             fieldOdd
);
  cntStrobe_t stb;
  logic lastPix, lastLine;

  raster_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pipeEn(pipeEn), .interlaceEn(interlaceEn),
    .oddFirst(oddFirst), .lastPix(lastPix), .lastLine(lastLine),
    .stb(stb), .fieldOdd(fieldOdd)
  );

  raster_dp #(.HW(HW), .VW(VW)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hTotalWord(hTotalWord), .hSyncWord(hSyncWord), .hBlankWord(hBlankWord),
    .vTotalWord(vTotalWord), .vSyncWord(vSyncWord), .vBlankWord(vBlankWord),
    .srcSizeWord(srcSizeWord), .hSyncPolHigh(hSyncPolHigh),
    .vSyncPolHigh(vSyncPolHigh), .pwrState(pwrState),
    .lastPix(lastPix), .lastLine(lastLine),
    .hSync(hSync), .vSync(vSync), .hBlank(hBlank), .vBlank(vBlank),
    .dispActive(dispActive), .scanLine(scanLine)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int VW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          pipeEn,
  input logic          hSyncPolHigh,
  input logic          vSyncPolHigh,
  input logic [1:0]    pwrState,
  input logic          hSync,
  input logic          vSync,
  input logic [VW-1:0] scanLine,
  input logic          fieldOdd
);
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pipeEn |=> $stable(scanLine)); // R8

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pipeEn |=> (scanLine == $past(scanLine) || scanLine == $past(scanLine) + 1'b1
                || scanLine == '0)); // R1

  AST_FIELD_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fieldOdd) |-> scanLine == '0); // R10

  AST_PWR_BOTH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd3 |-> (hSync == !hSyncPolHigh && vSync == !vSyncPolHigh)); // R6

  AST_PWR_H_OFF: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == 2'd1 |-> hSync == !hSyncPolHigh); // R6
endmodule

bind raster_timing_gen raster_timing_chk #(.VW(VW)) i_chk (
  .clk(clk), .rstN(rstN), .pipeEn(pipeEn), .hSyncPolHigh(hSyncPolHigh),
  .vSyncPolHigh(vSyncPolHigh), .pwrState(pwrState), .hSync(hSync),
  .vSync(vSync), .scanLine(scanLine), .fieldOdd(fieldOdd)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int HW = 12;
  localparam int VW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pipeEn = 1'b0;
  logic [2*HW-1:0] hTotalWord, hSyncWord, hBlankWord;
  logic [2*VW-1:0] vTotalWord, vSyncWord, vBlankWord;
  logic [HW+VW-1:0] srcSizeWord;
  logic hSyncPolHigh = 1'b1, vSyncPolHigh = 1'b0;
  logic [1:0] pwrState = 2'd0;
  logic interlaceEn = 1'b0, oddFirst = 1'b0;
  logic hSync, vSync, hBlank, vBlank, dispActive, fieldOdd;
  logic [VW-1:0] scanLine;

  int checks = 0;
  int fails = 0;
  int tRun = 0;

  always #5 clk = ~clk;

  raster_timing_gen #(.HW(HW), .VW(VW)) i_raster_timing_gen (.*);

  // {t[15:0], line[7:0], 3'b0, hs, vs, hb, vb, act}
  localparam int NV = 14;
  localparam logic [31:0] VEC [NV] = '{
    {16'd0,   8'd0, 8'b000_01001}, {16'd6,   8'd0, 8'b000_01000},
    {16'd8,   8'd0, 8'b000_01100}, {16'd26,  8'd1, 8'b000_11100},
    {16'd28,  8'd1, 8'b000_11100}, {16'd29,  8'd1, 8'b000_01100},
    {16'd31,  8'd1, 8'b000_01100}, {16'd37,  8'd2, 8'b000_01001},
    {16'd55,  8'd3, 8'b000_01000}, {16'd64,  8'd4, 8'b000_01010},
    {16'd83,  8'd5, 8'b000_00010}, {16'd99,  8'd6, 8'b000_00010},
    {16'd115, 8'd7, 8'b000_01010}, {16'd131, 8'd8, 8'b000_01000}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at t=%0d: actual %0d expected %0d", req, tRun, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (pipeEn) tRun++;
  endtask

  task automatic stepTo(input int target);
    while (tRun < target) tick();
    #1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    hTotalWord  = {12'd15, 12'd7};
    hSyncWord   = {12'd12, 12'd9};
    hBlankWord  = {12'd15, 12'd7};
    vTotalWord  = {12'd8,  12'd3};
    vSyncWord   = {12'd6,  12'd4};
    vBlankWord  = {12'd7,  12'd3};
    srcSizeWord = {12'd5,  12'd2};
    repeat (3) @(negedge clk);
    #1;
    chk("R11 scanLine in reset", scanLine, 0);
    chk("R11 fieldOdd in reset", fieldOdd, 0);
    chk("R11 hSync inactive", hSync, 0);
    chk("R11 vSync inactive", vSync, 1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 idle before enable", scanLine, 0);
    pipeEn = 1'b1;
    @(negedge clk);       // load edge passes without a step (R7)
    tRun = 0;

    // table walk across frame 0
    for (int i = 0; i < NV; i++) begin
      stepTo(int'(VEC[i][31:16]));
      chk("R1 line", scanLine, int'(VEC[i][15:8]));
      chk("R2 hsync", hSync, int'(VEC[i][4]));
      chk("R5 vsync active low", vSync, int'(VEC[i][3]));
      chk("R3 hblank", hBlank, int'(VEC[i][2]));
      chk("R3 vblank", vBlank, int'(VEC[i][1]));
      chk("R4 active", dispActive, int'(VEC[i][0]));
    end

    stepTo(143); chk("R1 last line", scanLine, 8);
    stepTo(144); chk("R1 wrap", scanLine, 0);

    // power states and polarity, both raw syncs active at v5 h10
    stepTo(234);
    pwrState = 2'd3; #1;
    chk("R6 off hsync", hSync, 0); chk("R6 off vsync", vSync, 1);
    pwrState = 2'd1; #1;
    chk("R6 hoff hsync", hSync, 0); chk("R6 hoff vsync", vSync, 0);
    pwrState = 2'd2; #1;
    chk("R6 voff hsync", hSync, 1); chk("R6 voff vsync", vSync, 1);
    pwrState = 2'd0; #1;
    chk("R6 on hsync", hSync, 1); chk("R6 on vsync", vSync, 0);
    hSyncPolHigh = 1'b0; vSyncPolHigh = 1'b1; #1;
    chk("R5 hsync low pol", hSync, 0); chk("R5 vsync high pol", vSync, 1);
    hSyncPolHigh = 1'b1; vSyncPolHigh = 1'b0;

    // mid-frame rewrite waits for the frame boundary
    stepTo(244);
    hTotalWord = {12'd31, 12'd7};
    stepTo(272); chk("R7 old length kept", scanLine, 8);
    stepTo(288); chk("R7 boundary", scanLine, 0);
    stepTo(304); chk("R7 new length", scanLine, 0);
    stepTo(320); chk("R7 new length line1", scanLine, 1);
    stepTo(330);
    hTotalWord = {12'd15, 12'd7};
    stepTo(575); chk("R7 long frame end", scanLine, 8);
    stepTo(576); chk("R7 long frame wrap", scanLine, 0);

    // pipe stop at v2 h8
    stepTo(616);
    chk("R8 before stop", scanLine, 2);
    pipeEn = 1'b0;
    repeat (30) tick();
    #1;
    chk("R8 line held", scanLine, 2);
    chk("R8 hblank held", hBlank, 1);
    pipeEn = 1'b1;
    stepTo(623); chk("R8 resumed", scanLine, 2);
    stepTo(624); chk("R8 resumed next", scanLine, 3);

    // interlace, requested mid-frame
    stepTo(650);
    chk("R10 progressive field", fieldOdd, 0);
    interlaceEn = 1'b1; oddFirst = 1'b1;
    stepTo(720);
    chk("R10 first field", fieldOdd, 1); chk("R9 field top", scanLine, 0);
    stepTo(863); chk("R9 last full line", scanLine, 8);
    stepTo(864);
    chk("R9 half line number", scanLine, 8);
    chk("R9 half hblank", hBlank, 1);
    chk("R9 half vblank", vBlank, 1);
    chk("R9 half inactive", dispActive, 0);
    stepTo(871); chk("R9 half line end", scanLine, 8);
    stepTo(872);
    chk("R9 second field top", scanLine, 0);
    chk("R10 toggled", fieldOdd, 0);
    stepTo(1023); chk("R9 second half line", scanLine, 8);
    stepTo(1024);
    chk("R10 toggled back", fieldOdd, 1);
    chk("R9 third field top", scanLine, 0);

    finishRun();
  end
endmodule